// File: doc/BRIEF.md
# Phase-Interpolating Fractional Divider Controller

This block produces the digital control for a fractional frequency divider that runs on a fast oscillator clock. A down-counter divides the oscillator clock by an integer modulus N or N+1. On every divider output cycle, an m-bit phase accumulator adds a fraction word x. The accumulator's overflow picks the longer modulus for the next output interval. The accumulator's value picks one of 2^m equally spaced copies of the oscillator clock. These copies come from an external delay line and arrive as an input vector. The chosen copy forms the divider's output edge.

Each output edge is delayed by a growing number of sub-cycle phase steps. When the accumulator wraps, the delay drops back to zero, and the one extra oscillator cycle of the N+1 interval makes up the missing whole period. Edge-to-edge spacing is therefore constant at N·2^m + x phase steps. The average ratio is N + x/2^m.

The counter is controlled by a three-state machine:
- **INIT** is entered on reset. It lasts one cycle, loads the first count and moves to RUN.
- **RUN** counts down. It moves to EDGE when the count reaches one.
- **EDGE** is the single cycle of the output edge. It steps the accumulator, reloads the counter and returns to RUN.

Top module: `frac_phase_divider`

## Requirements
- R1: While reset is held, edge_strobe, div_out, plus_one and phase_sel are all 0. After reset is released, the first edge_strobe appears in the cycle after the N-th rising clock edge. During that first interval, phase_sel and plus_one stay 0.
- R2: edge_strobe is high for exactly one cycle per output interval. The distance from one strobe to the next is N+1 cycles when phase_sel plus frac_x, both sampled during the earlier strobe, reaches 2^m or more, and N cycles otherwise.
- R3: Leaving a strobe cycle, phase_sel becomes (phase_sel + frac_x) mod 2^m. It keeps that value until the next strobe cycle has ended.
- R4: plus_one holds, for a whole interval, the overflow bit that chose that interval's N+1 length. It is 1 exactly for N+1 intervals.
- R5: div_out equals phases[phase_sel] during a strobe cycle and is 0 in every other cycle. Bit i of phases is the clock copy delayed by i/2^m of a period.
- R6: A div_n value of 0 or 1 acts as a modulus of 2.
- R7: div_n and frac_x are sampled only on the clock edge that ends a strobe cycle, and div_n also on the first edge after reset. Changes at any other time do not affect the interval in progress.
- R8: With interval length L and phase_sel values s0 before and s1 after, the edge spacing is L·2^m + s1 − s0 phase steps. It equals N·2^m + x for every interval, where N and x are the values sampled at the start of that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_n | input | DIV_W | Integer modulus N |
| frac_x | input | ACC_W | Fraction word x, in units of 1/2^m |
| phases | input | 2^ACC_W | Equally spaced delayed copies of clk |
| edge_strobe | output | 1 | High in the output-edge cycle |
| phase_sel | output | ACC_W | Registered phase index |
| plus_one | output | 1 | Current interval is N+1 long |
| div_out | output | 1 | Gated selected phase, the divider output |

## Verification
The strobe is a Moore output of the state register, so it appears one cycle after the counter reaches one. phase_sel and plus_one change on the clock edge that ends a strobe, so the bench expects the new values from the next cycle on. div_out is combinational, and the bench compares it in the same cycle as the phases it sees. The bench drives inputs 2 ns after a rising edge and samples on the falling edge. It records div_n, frac_x and phase_sel while a strobe is high, and it checks the following interval's length, carry and spacing against those recorded values.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_EDGE = 2'd2
    } fdiv_state_e;

    localparam int unsigned MIN_MODULUS = 2;

endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
    parameter int ACC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [ACC_W-1:0] frac_x,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry_nxt,
    output logic             plus_q
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum       = {1'b0, acc_q} + {1'b0, frac_x};
        carry_nxt = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            plus_q <= 1'b0;
        end else if (step) begin
            acc_q  <= sum[ACC_W-1:0];
            plus_q <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/fdiv_mod_counter.sv
module fdiv_mod_counter
    import fdiv_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n,
    input  logic             add_one,
    output logic             edge_cyc
);
    localparam int CNT_W = DIV_W + 1;

    fdiv_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_n;
    logic [CNT_W-1:0] first_load;
    logic [CNT_W-1:0] reload;

    always_comb begin
        eff_n      = (div_n < DIV_W'(MIN_MODULUS)) ? DIV_W'(MIN_MODULUS) : div_n;
        first_load = CNT_W'(eff_n) - CNT_W'(1);
        reload     = first_load + CNT_W'(add_one);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_RUN;
            ST_RUN:  state_d = (cnt_q == CNT_W'(1)) ? ST_EDGE : ST_RUN;
            ST_EDGE: state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_INIT: cnt_q <= first_load;
                ST_RUN:  cnt_q <= cnt_q - CNT_W'(1);
                ST_EDGE: cnt_q <= reload;
                default: cnt_q <= '0;
            endcase
        end
    end

    assign edge_cyc = (state_q == ST_EDGE);
endmodule

// File: rtl/fdiv_phase_mux.sv
module fdiv_phase_mux #(
    parameter int ACC_W = 3
) (
    input  logic [(1<<ACC_W)-1:0] phases,
    input  logic [ACC_W-1:0]      sel,
    input  logic                  gate,
    output logic                  out
);
    localparam int NPH = 1 << ACC_W;

    logic [NPH-1:0] hit;

    for (genvar i = 0; i < NPH; i++) begin : g_tap
        assign hit[i] = phases[i] & (sel == ACC_W'(i));
    end

    assign out = gate & (|hit);
endmodule

// File: rtl/frac_phase_divider.sv
module frac_phase_divider #(
    parameter int DIV_W = 6,
    parameter int ACC_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      div_n,
    input  logic [ACC_W-1:0]      frac_x,
    input  logic [(1<<ACC_W)-1:0] phases,
    output logic                  edge_strobe,
    output logic [ACC_W-1:0]      phase_sel,
    output logic                  plus_one,
    output logic                  div_out
);
    logic edge_cyc;
    logic carry_nxt;

    fdiv_mod_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_n    (div_n),
        .add_one  (carry_nxt),
        .edge_cyc (edge_cyc)
    );

    fdiv_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (edge_cyc),
        .frac_x    (frac_x),
        .acc_q     (phase_sel),
        .carry_nxt (carry_nxt),
        .plus_q    (plus_one)
    );

    fdiv_phase_mux #(.ACC_W(ACC_W)) u_mux (
        .phases (phases),
        .sel    (phase_sel),
        .gate   (edge_cyc),
        .out    (div_out)
    );

    assign edge_strobe = edge_cyc;
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
    parameter int DIV_W = 6,
    parameter int ACC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_n,
    input logic [ACC_W-1:0] frac_x,
    input logic             edge_strobe,
    input logic [ACC_W-1:0] phase_sel,
    input logic             plus_one,
    input logic             div_out
);
    localparam int CNT_W = DIV_W + 2;

    logic [ACC_W:0]   nxt;
    logic [CNT_W-1:0] gap_q, exp_q, eff;
    logic             seen_q;

    assign nxt = {1'b0, phase_sel} + {1'b0, frac_x};
    assign eff = (div_n < DIV_W'(2)) ? CNT_W'(2) : CNT_W'(div_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            exp_q  <= '0;
            seen_q <= 1'b0;
        end else if (edge_strobe) begin
            gap_q  <= CNT_W'(1);
            exp_q  <= eff + CNT_W'(nxt[ACC_W]);
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + CNT_W'(1);
        end
    end

    // R2 R6 R7: interval length follows the modulus sampled at the previous edge
    assert_interval_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_strobe && seen_q) |-> (gap_q == exp_q));

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_strobe |=> !edge_strobe);

    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_strobe |=> $stable(phase_sel));

    assert_sel_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_strobe |=> (phase_sel == $past(nxt[ACC_W-1:0])));

    assert_plus_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_strobe |=> (plus_one == $past(nxt[ACC_W])));

    assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> edge_strobe);
endmodule

bind frac_phase_divider fdiv_checker #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u_fdiv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_n       (div_n),
    .frac_x      (frac_x),
    .edge_strobe (edge_strobe),
    .phase_sel   (phase_sel),
    .plus_one    (plus_one),
    .div_out     (div_out)
);

// File: tb/tb_frac_phase_divider.sv
module tb_frac_phase_divider;
    localparam int DIV_W = 6;
    localparam int ACC_W = 3;
    localparam int NPH   = 1 << ACC_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] div_n;
    logic [ACC_W-1:0] frac_x;
    logic [NPH-1:0]   phases;
    logic             edge_strobe;
    logic [ACC_W-1:0] phase_sel;
    logic             plus_one;
    logic             div_out;

    int n_chk = 0, n_fail = 0;
    int gap = 0, pn = 0, px = 0, psel = 0, start_n = 0;
    bit have_prev = 0, done = 0;

    always #5 clk = ~clk;

    frac_phase_divider #(.DIV_W(DIV_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n), .div_n(div_n), .frac_x(frac_x),
        .phases(phases), .edge_strobe(edge_strobe), .phase_sel(phase_sel),
        .plus_one(plus_one), .div_out(div_out)
    );

    function automatic int eff_n(int n);
        return (n < 2) ? 2 : n;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: samples on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                gap = 0; have_prev = 0;
                chk(!edge_strobe && !div_out && !plus_one && phase_sel == 0,
                    "R1 reset outputs", {edge_strobe, div_out, plus_one, phase_sel}, 0);
            end else begin
                int c, esel;
                gap++;
                c    = have_prev ? int'((psel + px) >= NPH) : 0;
                esel = have_prev ? (psel + px) % NPH : 0;
                chk(phase_sel == esel, have_prev ? "R3 phase_sel" : "R1 phase_sel", phase_sel, esel);
                chk(plus_one == c, have_prev ? "R4 plus_one" : "R1 plus_one", plus_one, c);
                if (edge_strobe) begin
                    if (!have_prev) begin
                        chk(gap == eff_n(start_n) + 1, "R1 first edge", gap, eff_n(start_n) + 1);
                    end else begin
                        int el, sp, esp;
                        el  = eff_n(pn) + c;
                        chk(gap == el, "R2 R6 R7 interval", gap, el);
                        sp  = gap * NPH + int'(phase_sel) - psel;
                        esp = eff_n(pn) * NPH + px;
                        chk(sp == esp, "R8 spacing", sp, esp);
                    end
                    chk(div_out == phases[phase_sel], "R5 div_out edge", div_out, phases[phase_sel]);
                    pn = div_n; px = frac_x; psel = phase_sel;
                    have_prev = 1; gap = 0;
                end else begin
                    chk(div_out == 1'b0, "R5 div_out idle", div_out, 0);
                end
            end
        end
    end

    initial begin
        phases = '0;
        forever begin
            @(posedge clk); #2;
            phases = NPH'($urandom);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_strobes(int k);
        repeat (k) begin
            @(negedge clk);
            while (!edge_strobe) @(negedge clk);
        end
        @(posedge clk); #2;
    endtask

    task automatic seg(int n, int x, int k);
        div_n = DIV_W'(n); frac_x = ACC_W'(x);
        wait_strobes(k);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        finish_run();
    end

    initial begin
        int s;
        s = $urandom(32'd4711);
        rst_n = 1'b0; div_n = 6'd5; frac_x = 3'd2; start_n = 5;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        seg(5, 2, 12);   // R8 example ratio N + 2/8
        seg(5, 0, 6);    // integer mode: no carry, phase_sel frozen (R3 R4)
        seg(5, 7, 10);   // carry on most edges
        seg(1, 3, 10);   // R6 modulus clamp
        seg(0, 5, 10);   // R6
        seg(63, 7, 4);   // widest modulus with carry
        seg(2, 7, 10);
        seg(4, 1, 10);
        for (int i = 0; i < 80; i++) begin // R7 changes land mid-interval
            repeat ($urandom_range(0, 25)) @(posedge clk);
            #2;
            div_n  = DIV_W'($urandom_range(0, 20));
            frac_x = ACC_W'($urandom_range(0, NPH - 1));
        end
        wait_strobes(3);
        finish_run();
    end
endmodule